// File: doc/BRIEF.md
# Bridge Frame Address Filter

This block sits behind the receiver of one port of a two-port network bridge. It makes the first routing decision for every frame that arrives. Frames come in as a byte stream. Byte 0 carries the destination station and byte 1 the destination network. The filter keeps one reachability bitmap per side, with one bit for each network number. It decides after byte 1 whether the frame can be dropped at once. A destination network of zero means the sender's own segment, so such a frame is always dropped. A network whose bit is clear in the bitmap of the arrival side is also dropped.

A frame that passes the address check has every byte from index 2 onward captured into a small payload buffer. At the last byte, the receiver's end-of-frame valid flag is checked and the frame is classified. A broadcast to station and network all-ones whose port byte is the bridge-protocol port, and whose control byte falls in the protocol window, goes to a protocol-handler output with a handler select. Every other good frame is marked for forwarding.

The reachability bitmaps are loaded at reset with the bridge's own two network numbers and the broadcast network. A single-entry set/clear write port lets a protocol handler learn or forget routes at run time. A later stage uses the verdict and reads the captured bytes through a read port.

Top module: `bridge_frame_filter`

## Requirements
- R1: After reset, on both sides, exactly the networks OWN_NET_A, OWN_NET_B and all-ones (255) are marked reachable. `res_valid` is low until a frame is presented.
- R2: A frame whose byte 1 is 0 produces one result (verdict DROP=0, reason 1) in the cycle after byte 1 is accepted. The remaining bytes of that frame produce no result.
- R3: A frame whose byte 1 is non-zero and not marked in the table of side `in_side` (sampled with byte 1, 0 or 1) is dropped in the cycle after byte 1 is accepted, with reason 2. The remaining bytes produce no result.
- R4: A pulse on `tbl_we` with `tbl_set`=1 marks network `tbl_net` reachable on side `tbl_side`; with `tbl_set`=0 it clears the mark. Frames whose byte 1 is accepted after that write edge see the new value.
- R5: Frame bytes from index 2 onward are stored at buffer addresses 0, 1, … in arrival order. `res_len` gives the count stored. `buf_rd_data` returns the byte at `buf_rd_addr`.
- R6: A frame with more than BUF_DEPTH bytes after the header is dropped with reason 4. Only the first BUF_DEPTH of those bytes are stored, and `res_len` never exceeds BUF_DEPTH.
- R7: If `in_frame_ok` is low with the last byte, a frame that passed the address check is dropped with reason 3. This takes priority over reasons 4 and 5.
- R8: A frame that does not pass the address check early and has fewer than 4 bytes in total is dropped with reason 5.
- R9: A frame with byte 0 = 0xFF, byte 1 = 0xFF, byte 3 (port) = PROTO_PORT (0x9C) and byte 2 (control) in CTRL_BASE .. CTRL_BASE+NUM_CTRL-1 (0x80..0x83) gets verdict PROTO=2 and `res_ctrl_sel` = control − CTRL_BASE.
- R10: Every other valid frame of 4 or more bytes that passes the address check gets verdict FORWARD=1. The reason is 0 exactly when the verdict is not DROP.
- R11: Each frame gives exactly one `res_valid` pulse. It comes one cycle after the deciding byte: byte 1 for R2/R3 drops, byte 0 or 1 for short frames that end there, and the last byte otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_data | input | DATA_W | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_frame_ok | input | 1 | Receiver end-of-frame valid flag, sampled with the last byte |
| in_side | input | 1 | Arrival side, sampled with byte 1 |
| tbl_we | input | 1 | Table write strobe |
| tbl_side | input | 1 | Table side to write |
| tbl_net | input | DATA_W | Network number to write |
| tbl_set | input | 1 | 1 marks reachable, 0 clears |
| res_valid | output | 1 | One-cycle result pulse |
| res_verdict | output | 2 | 0 drop, 1 forward, 2 protocol |
| res_reason | output | 3 | Drop reason code, 0 when not dropped |
| res_ctrl_sel | output | SEL_W | Protocol handler select |
| res_dst_stn | output | DATA_W | Destination station of the frame |
| res_dst_net | output | DATA_W | Destination network of the frame |
| res_len | output | LEN_W | Number of bytes captured |
| buf_rd_addr | input | LEN_W | Payload buffer read address |
| buf_rd_data | output | DATA_W | Payload buffer read data |

## Verification
The bench builds the filter with BUF_DEPTH lowered to 8 and the own networks moved to 0x06 and 0x2A. With the smaller depth, random frame lengths regularly cross the overflow boundary and land exactly on it. With non-default own networks, a table reset that ignored the parameters would be detected. Random table writes between frames sometimes clear the own or broadcast entries, so R1 and R4 interact under random traffic, and broadcast frames near the protocol window test both sides of the port and control comparisons.

// File: rtl/bfilt_pkg.sv
package bfilt_pkg;

   typedef enum logic [1:0] {
      VERD_DROP  = 2'd0,
      VERD_FWD   = 2'd1,
      VERD_PROTO = 2'd2
   } verdict_e;

   typedef enum logic [2:0] {
      RSN_NONE     = 3'd0,
      RSN_NET_ZERO = 3'd1,
      RSN_UNREACH  = 3'd2,
      RSN_BAD_END  = 3'd3,
      RSN_OVERFLOW = 3'd4,
      RSN_RUNT     = 3'd5
   } reason_e;

   typedef enum logic [1:0] {
      ST_STN  = 2'd0,
      ST_NET  = 2'd1,
      ST_BODY = 2'd2,
      ST_SKIP = 2'd3
   } hdr_state_e;

endpackage

// File: rtl/bfilt_reach_table.sv
module bfilt_reach_table #(
   parameter int DATA_W    = 8,
   parameter int OWN_NET_A = 1,
   parameter int OWN_NET_B = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_side,
   input  logic [DATA_W-1:0] wr_net,
   input  logic              wr_set,
   input  logic              lk_side,
   input  logic [DATA_W-1:0] lk_net,
   output logic              lk_hit
);
   localparam int DEPTH = 1 << DATA_W;
   localparam int BCAST = DEPTH - 1;

   generate
      if (OWN_NET_A <= 0 || OWN_NET_A >= BCAST) begin : g_bad_a
         $error("OWN_NET_A must lie strictly between 0 and the broadcast network");
      end
      if (OWN_NET_B <= 0 || OWN_NET_B >= BCAST) begin : g_bad_b
         $error("OWN_NET_B must lie strictly between 0 and the broadcast network");
      end
   endgenerate

   logic [1:0] hit_side;

   for (genvar s = 0; s < 2; s++) begin : g_side
      logic [DEPTH-1:0] bits;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bits            <= '0;
            bits[OWN_NET_A] <= 1'b1;
            bits[OWN_NET_B] <= 1'b1;
            bits[BCAST]     <= 1'b1;
         end else if (wr_en && (int'(wr_side) == s)) begin
            bits[wr_net] <= wr_set;
         end
      end

      assign hit_side[s] = bits[lk_net];

      AST_TBL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && (int'(wr_side) == s)) |=> (bits[$past(wr_net)] == $past(wr_set))); // R4
   end

   assign lk_hit = lk_side ? hit_side[1] : hit_side[0];

endmodule

// File: rtl/bfilt_payload_buf.sv
module bfilt_payload_buf #(
   parameter int DATA_W    = 8,
   parameter int BUF_DEPTH = 20,
   parameter int ADDR_W    = 5
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int SLOTS = 1 << ADDR_W;

   generate
      if (SLOTS < BUF_DEPTH) begin : g_bad_addr
         $error("ADDR_W too narrow for BUF_DEPTH");
      end
   endgenerate

   logic [DATA_W-1:0] mem [SLOTS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = (int'(rd_addr) < BUF_DEPTH) ? mem[rd_addr] : '0;

endmodule

// File: rtl/bfilt_hdr_ctl.sv
module bfilt_hdr_ctl
   import bfilt_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int BUF_DEPTH  = 20,
   parameter int LEN_W      = 5,
   parameter int PROTO_PORT = 'h9C,
   parameter int CTRL_BASE  = 'h80,
   parameter int NUM_CTRL   = 4,
   parameter int SEL_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   input  logic              in_frame_ok,
   input  logic              lk_hit,
   output logic              buf_we,
   output logic [LEN_W-1:0]  buf_waddr,
   output logic              res_valid,
   output verdict_e          res_verdict,
   output reason_e           res_reason,
   output logic [SEL_W-1:0]  res_ctrl_sel,
   output logic [DATA_W-1:0] res_dst_stn,
   output logic [DATA_W-1:0] res_dst_net,
   output logic [LEN_W-1:0]  res_len
);
   localparam logic [LEN_W-1:0]  FULL     = LEN_W'(BUF_DEPTH);
   localparam logic [LEN_W-1:0]  ONE      = LEN_W'(1);
   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] PPORT    = DATA_W'(PROTO_PORT);

   hdr_state_e        state_q, state_d;
   logic [LEN_W-1:0]  cnt_q;
   logic              ovf_q;
   logic [DATA_W-1:0] stn_q, net_q, ctrl_q, port_q;

   logic              emit;
   verdict_e          verd_d;
   reason_e           rsn_d;
   logic [SEL_W-1:0]  sel_d;
   logic              store;
   logic [DATA_W-1:0] port_now;
   int                ctrl_off;
   logic              is_proto;

   assign port_now = (cnt_q == ONE) ? in_data : port_q;
   assign ctrl_off = int'(ctrl_q) - CTRL_BASE;
   assign is_proto = (stn_q == ALL_ONES) && (net_q == ALL_ONES) && (port_now == PPORT)
                     && (ctrl_off >= 0) && (ctrl_off < NUM_CTRL);

   always_comb begin
      state_d = state_q;
      emit    = 1'b0;
      verd_d  = VERD_DROP;
      rsn_d   = RSN_NONE;
      sel_d   = '0;
      store   = 1'b0;
      case (state_q)
         ST_STN: begin
            if (in_valid) begin
               if (in_last) begin
                  emit  = 1'b1;
                  rsn_d = RSN_RUNT;
               end else begin
                  state_d = ST_NET;
               end
            end
         end
         ST_NET: begin
            if (in_valid) begin
               if (in_data == '0) begin
                  emit    = 1'b1;
                  rsn_d   = RSN_NET_ZERO;
                  state_d = in_last ? ST_STN : ST_SKIP;
               end else if (!lk_hit) begin
                  emit    = 1'b1;
                  rsn_d   = RSN_UNREACH;
                  state_d = in_last ? ST_STN : ST_SKIP;
               end else if (in_last) begin
                  emit    = 1'b1;
                  rsn_d   = RSN_RUNT;
                  state_d = ST_STN;
               end else begin
                  state_d = ST_BODY;
               end
            end
         end
         ST_BODY: begin
            if (in_valid) begin
               store = (cnt_q < FULL);
               if (in_last) begin
                  emit    = 1'b1;
                  state_d = ST_STN;
                  if (!in_frame_ok) begin
                     rsn_d = RSN_BAD_END;
                  end else if (ovf_q || (cnt_q == FULL)) begin
                     rsn_d = RSN_OVERFLOW;
                  end else if (cnt_q == '0) begin
                     rsn_d = RSN_RUNT;
                  end else if (is_proto) begin
                     verd_d = VERD_PROTO;
                     sel_d  = SEL_W'(ctrl_off);
                  end else begin
                     verd_d = VERD_FWD;
                  end
               end
            end
         end
         ST_SKIP: begin
            if (in_valid && in_last) state_d = ST_STN;
         end
         default: state_d = ST_STN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_STN;
         cnt_q        <= '0;
         ovf_q        <= 1'b0;
         stn_q        <= '0;
         net_q        <= '0;
         ctrl_q       <= '0;
         port_q       <= '0;
         res_valid    <= 1'b0;
         res_verdict  <= VERD_DROP;
         res_reason   <= RSN_NONE;
         res_ctrl_sel <= '0;
         res_dst_stn  <= '0;
         res_dst_net  <= '0;
         res_len      <= '0;
      end else begin
         state_q   <= state_d;
         res_valid <= emit;
         if (in_valid) begin
            case (state_q)
               ST_STN: begin
                  stn_q <= in_data;
                  cnt_q <= '0;
                  ovf_q <= 1'b0;
               end
               ST_NET: net_q <= in_data;
               ST_BODY: begin
                  if (cnt_q == '0) ctrl_q <= in_data;
                  if (cnt_q == ONE) port_q <= in_data;
                  if (store) cnt_q <= cnt_q + ONE;
                  else       ovf_q <= 1'b1;
               end
               default: ;
            endcase
         end
         if (emit) begin
            res_verdict  <= verd_d;
            res_reason   <= rsn_d;
            res_ctrl_sel <= sel_d;
            res_dst_stn  <= (state_q == ST_STN) ? in_data : stn_q;
            res_dst_net  <= (state_q == ST_STN) ? '0 :
                            (state_q == ST_NET) ? in_data : net_q;
            res_len      <= (state_q != ST_BODY) ? '0 :
                            store ? (cnt_q + ONE) : cnt_q;
         end
      end
   end

   assign buf_we    = store;
   assign buf_waddr = cnt_q;

   AST_NET0_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (res_dst_net == '0)) |-> (res_verdict == VERD_DROP)); // R2
   AST_PROTO_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (res_verdict == VERD_PROTO)) |-> ((res_dst_stn == ALL_ONES) && (res_dst_net == ALL_ONES))); // R9
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (res_len <= FULL)); // R6
   AST_REASON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ((res_verdict == VERD_DROP) == (res_reason != RSN_NONE))); // R10
   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |=> !res_valid); // R11

endmodule

// File: rtl/bridge_frame_filter.sv
module bridge_frame_filter #(
   parameter int DATA_W     = 8,
   parameter int BUF_DEPTH  = 20,
   parameter int OWN_NET_A  = 1,
   parameter int OWN_NET_B  = 2,
   parameter int PROTO_PORT = 'h9C,
   parameter int CTRL_BASE  = 'h80,
   parameter int NUM_CTRL   = 4,
   localparam int SEL_W     = $clog2(NUM_CTRL),
   localparam int LEN_W     = $clog2(BUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   input  logic              in_frame_ok,
   input  logic              in_side,
   input  logic              tbl_we,
   input  logic              tbl_side,
   input  logic [DATA_W-1:0] tbl_net,
   input  logic              tbl_set,
   output logic              res_valid,
   output logic [1:0]        res_verdict,
   output logic [2:0]        res_reason,
   output logic [SEL_W-1:0]  res_ctrl_sel,
   output logic [DATA_W-1:0] res_dst_stn,
   output logic [DATA_W-1:0] res_dst_net,
   output logic [LEN_W-1:0]  res_len,
   input  logic [LEN_W-1:0]  buf_rd_addr,
   output logic [DATA_W-1:0] buf_rd_data
);
   import bfilt_pkg::*;

   generate
      if (DATA_W < 4 || DATA_W > 10) begin : g_bad_w
         $error("DATA_W must be between 4 and 10");
      end
      if (BUF_DEPTH < 2) begin : g_bad_depth
         $error("BUF_DEPTH must hold at least control and port bytes");
      end
      if (NUM_CTRL < 2 || (NUM_CTRL & (NUM_CTRL - 1)) != 0) begin : g_bad_ctrl
         $error("NUM_CTRL must be a power of two of at least 2");
      end
      if (CTRL_BASE + NUM_CTRL > (1 << DATA_W) || PROTO_PORT >= (1 << DATA_W)) begin : g_bad_code
         $error("protocol codes do not fit a frame byte");
      end
   endgenerate

   logic             lk_hit;
   logic             buf_we;
   logic [LEN_W-1:0] buf_waddr;
   verdict_e         verd;
   reason_e          rsn;

   bfilt_reach_table #(
      .DATA_W   (DATA_W),
      .OWN_NET_A(OWN_NET_A),
      .OWN_NET_B(OWN_NET_B)
   ) table_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_we),
      .wr_side(tbl_side),
      .wr_net (tbl_net),
      .wr_set (tbl_set),
      .lk_side(in_side),
      .lk_net (in_data),
      .lk_hit (lk_hit)
   );

   bfilt_hdr_ctl #(
      .DATA_W    (DATA_W),
      .BUF_DEPTH (BUF_DEPTH),
      .LEN_W     (LEN_W),
      .PROTO_PORT(PROTO_PORT),
      .CTRL_BASE (CTRL_BASE),
      .NUM_CTRL  (NUM_CTRL),
      .SEL_W     (SEL_W)
   ) ctl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .in_last     (in_last),
      .in_frame_ok (in_frame_ok),
      .lk_hit      (lk_hit),
      .buf_we      (buf_we),
      .buf_waddr   (buf_waddr),
      .res_valid   (res_valid),
      .res_verdict (verd),
      .res_reason  (rsn),
      .res_ctrl_sel(res_ctrl_sel),
      .res_dst_stn (res_dst_stn),
      .res_dst_net (res_dst_net),
      .res_len     (res_len)
   );

   bfilt_payload_buf #(
      .DATA_W   (DATA_W),
      .BUF_DEPTH(BUF_DEPTH),
      .ADDR_W   (LEN_W)
   ) buf_i (
      .clk    (clk),
      .wr_en  (buf_we),
      .wr_addr(buf_waddr),
      .wr_data(in_data),
      .rd_addr(buf_rd_addr),
      .rd_data(buf_rd_data)
   );

   assign res_verdict = verd;
   assign res_reason  = rsn;

endmodule

// File: tb/bridge_frame_filter_tb_top.sv
module bridge_frame_filter_tb_top;
   localparam int DW    = 8;
   localparam int DEPTH = 8;
   localparam int NETA  = 'h06;
   localparam int NETB  = 'h2A;
   localparam int SW    = 2;
   localparam int LW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_last = 1'b0, in_frame_ok = 1'b1, in_side = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          tbl_we = 1'b0, tbl_side = 1'b0, tbl_set = 1'b0;
   logic [DW-1:0] tbl_net = '0;
   logic          res_valid;
   logic [1:0]    res_verdict;
   logic [2:0]    res_reason;
   logic [SW-1:0] res_ctrl_sel;
   logic [DW-1:0] res_dst_stn, res_dst_net, buf_rd_data;
   logic [LW-1:0] res_len;
   logic [LW-1:0] buf_rd_addr = '0;

   always #4 clk = ~clk;

   bridge_frame_filter #(
      .DATA_W(DW), .BUF_DEPTH(DEPTH), .OWN_NET_A(NETA), .OWN_NET_B(NETB)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_frame_ok(in_frame_ok), .in_side(in_side),
      .tbl_we(tbl_we), .tbl_side(tbl_side), .tbl_net(tbl_net), .tbl_set(tbl_set),
      .res_valid(res_valid), .res_verdict(res_verdict), .res_reason(res_reason),
      .res_ctrl_sel(res_ctrl_sel), .res_dst_stn(res_dst_stn), .res_dst_net(res_dst_net),
      .res_len(res_len), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data)
   );

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;
   bit  model [2][256];
   logic [7:0] fb [0:31];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int s = 0; s < 2; s++) begin
         for (int n = 0; n < 256; n++) model[s][n] = 1'b0;
         model[s][NETA] = 1'b1;
         model[s][NETB] = 1'b1;
         model[s][255]  = 1'b1;
      end
   endfunction

   // expected result from the requirements
   function automatic void predict(input int n, input bit side, input bit ok,
                                   output int idx, output int verd, output int rsn,
                                   output int sel, output int elen, output string req);
      int body;
      verd = 0; sel = 0; elen = 0;
      if (n == 1) begin idx = 0; rsn = 5; req = "R8"; return; end
      if (fb[1] == 0) begin idx = 1; rsn = 1; req = "R2"; return; end
      if (!model[side][fb[1]]) begin idx = 1; rsn = 2; req = "R3"; return; end
      if (n == 2) begin idx = 1; rsn = 5; req = "R8"; return; end
      idx  = n - 1;
      body = n - 2;
      elen = (body > DEPTH) ? DEPTH : body;
      if (!ok)               begin rsn = 3; req = "R7"; end
      else if (body > DEPTH) begin rsn = 4; req = "R6"; end
      else if (body < 2)     begin rsn = 5; req = "R8"; end
      else if (fb[0] == 8'hFF && fb[1] == 8'hFF && fb[3] == 8'h9C &&
               fb[2] >= 8'h80 && fb[2] <= 8'h83) begin
         verd = 2; rsn = 0; sel = fb[2] - 8'h80; req = "R9";
      end else begin verd = 1; rsn = 0; req = "R10"; end
   endfunction

   task automatic tbl_write(input bit side, input int net, input bit set);
      @(negedge clk);
      tbl_we = 1'b1; tbl_side = side; tbl_net = DW'(net); tbl_set = set;
      @(negedge clk);
      tbl_we = 1'b0;
      model[side][net] = set;
   endtask

   task automatic send_frame(input int n, input bit side, input bit ok, input bit gaps);
      int got = 0, got_idx = -1, g_verd = 0, g_rsn = 0, g_sel = 0, g_len = 0;
      int idx, verd, rsn, sel, elen;
      string req;
      predict(n, side, ok, idx, verd, rsn, sel, elen, req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (gaps && ($urandom_range(3) == 0)) begin
            in_valid = 1'b0;
            @(posedge clk); #2;
            if (res_valid) begin got++; got_idx = 99; end
            @(negedge clk);
         end
         in_valid = 1'b1; in_data = fb[i]; in_last = (i == n - 1);
         in_side = side; in_frame_ok = ok;
         @(posedge clk); #2;
         if (res_valid) begin
            got++; got_idx = i;
            g_verd = res_verdict; g_rsn = res_reason; g_sel = res_ctrl_sel; g_len = res_len;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      @(posedge clk); #2;
      if (res_valid) got++;
      check(got == 1, "R11", "result pulse count", got, 1);
      check(got_idx == idx, "R11", "deciding byte index", got_idx, idx);
      check(g_verd == verd, req, "verdict", g_verd, verd);
      check(g_rsn == rsn, req, "reason", g_rsn, rsn);
      if (verd == 2) check(g_sel == sel, "R9", "handler select", g_sel, sel);
      if (idx == n - 1 && n > 2) begin
         check(g_len == elen, "R5", "captured length", g_len, elen);
         for (int k = 0; k < elen; k++) begin
            buf_rd_addr = LW'(k);
            #1;
            check(buf_rd_data == fb[k + 2], "R5", "buffer byte", buf_rd_data, fb[k + 2]);
         end
      end
   endtask

   task automatic fill(input int stn, input int net, input int ctrl, input int port, input int n);
      fb[0] = stn[7:0]; fb[1] = net[7:0]; fb[2] = ctrl[7:0]; fb[3] = port[7:0];
      for (int i = 4; i < n; i++) fb[i] = 8'($urandom);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0B1D));
      model_reset();
      repeat (3) @(posedge clk);
      #2;
      check(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #2;
      check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);

      // R1: reset table contents on both sides
      for (int s = 0; s < 2; s++) begin
         fill(8'h11, NETA, 8'h01, 8'h40, 6); send_frame(6, s, 1, 0);
         fill(8'h11, NETB, 8'h01, 8'h40, 6); send_frame(6, s, 1, 0);
         fill(8'h12, 255,  8'h01, 8'h40, 6); send_frame(6, s, 1, 0);
         fill(8'h12, NETA + 1, 8'h01, 8'h40, 6); send_frame(6, s, 1, 0);
      end
      // R2: local network, long tail
      fill(8'h05, 0, 8'h80, 8'h9C, 14); send_frame(14, 0, 1, 0);
      fill(8'h05, 0, 8'h80, 8'h9C, 2);  send_frame(2, 1, 1, 0);
      // R3, R4: learn and forget a route on one side only
      tbl_write(1, 'h10, 1);
      fill(8'h01, 'h10, 8'h00, 8'h01, 7); send_frame(7, 1, 1, 0);
      fill(8'h01, 'h10, 8'h00, 8'h01, 7); send_frame(7, 0, 1, 0);
      tbl_write(1, 'h10, 0);
      fill(8'h01, 'h10, 8'h00, 8'h01, 7); send_frame(7, 1, 1, 0);
      // R6: exactly full, one over
      fill(8'h03, NETA, 8'h00, 8'h01, DEPTH + 2); send_frame(DEPTH + 2, 0, 1, 0);
      fill(8'h03, NETA, 8'h00, 8'h01, DEPTH + 3); send_frame(DEPTH + 3, 0, 1, 0);
      // R7: bad end beats overflow
      fill(8'h03, NETB, 8'h00, 8'h01, DEPTH + 5); send_frame(DEPTH + 5, 1, 0, 0);
      fill(8'h03, NETB, 8'h00, 8'h01, 5); send_frame(5, 1, 0, 0);
      // R8: short frames
      fill(8'h03, NETB, 8'h00, 8'h01, 1); send_frame(1, 0, 1, 0);
      fill(8'h03, NETB, 8'h00, 8'h01, 2); send_frame(2, 0, 1, 0);
      fill(8'h03, NETB, 8'h00, 8'h01, 3); send_frame(3, 0, 1, 0);
      fill(8'h03, NETB, 8'h00, 8'h01, 4); send_frame(4, 0, 1, 0);
      // R9, R10: protocol window edges
      for (int c = 'h7F; c <= 'h84; c++) begin
         fill(8'hFF, 8'hFF, c, 8'h9C, 5); send_frame(5, c & 1, 1, 0);
      end
      fill(8'hFF, 8'hFF, 8'h81, 8'h9D, 4); send_frame(4, 0, 1, 0);
      fill(8'hFE, 8'hFF, 8'h81, 8'h9C, 4); send_frame(4, 0, 1, 0);
      fill(8'hFF, 8'hFF, 8'h82, 8'h9C, 4); send_frame(4, 1, 1, 1);

      // random traffic with route changes
      for (int f = 0; f < 400; f++) begin
         int n, net, pick, stn, ctrl, port;
         bit side, ok;
         if ($urandom_range(4) == 0) begin
            pick = $urandom_range(3);
            tbl_write($urandom_range(1),
                      (pick == 0) ? NETA : (pick == 1) ? 255 : $urandom_range(1, 15),
                      $urandom_range(1));
         end
         pick = $urandom_range(5);
         net  = (pick == 0) ? 0 : (pick == 1) ? NETA : (pick == 2) ? NETB :
                (pick == 3) ? 255 : $urandom_range(1, 15);
         stn  = ($urandom_range(1) == 0) ? 8'hFF : $urandom_range(255);
         ctrl = ($urandom_range(1) == 0) ? $urandom_range('h7E, 'h85) : $urandom_range(255);
         port = ($urandom_range(1) == 0) ? 8'h9C : $urandom_range(255);
         n    = $urandom_range(1, DEPTH + 6);
         side = $urandom_range(1);
         ok   = ($urandom_range(7) != 0);
         fill(stn, net, ctrl, port, n);
         send_frame(n, side, ok, 1);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule